// File: doc/BRIEF.md
# Folded Symmetric Low-Pass Filter with Block-Average Decimator

The block cleans up a slow stream of 12-bit unsigned samples from an analog-to-digital converter on a load-measurement channel. Each accepted sample enters a 17-stage delay line. Once the line is full, a 17-tap linear-phase low-pass response is computed. The coefficients come from a Hamming-windowed design with a normalized cutoff of 0.25 and are fixed when the block is built.

The coefficients are mirror-symmetric, so each pair of taps at equal distance from the centre is added before it is multiplied. One filter output therefore needs nine products. A single multiplier is shared over nine consecutive clocks, well inside the long interval between samples. A second stage sums each run of eight filter outputs and divides by eight. It rounds toward minus infinity, limits the value to the 12-bit range and emits one smoothed result with a one-clock strobe. The result rate is one eighth of the sample rate.

Top module: `fir_sym_avg`

## Requirements
- R1: While reset is held and directly after it, result_valid is 0 and result_data is 0.
- R2: No result appears until 17 samples have been accepted since reset. The 17th sample produces the first filter output and opens the first averaging group, so the first result follows the 24th sample.
- R3: For the newest sample x[n] and its predecessors x[n-k], the filter output is F = sum over k = 0..16 of c[k]*x[n-k]. The coefficients are c[0..8] = 0, -15, -47, -67, 0, 219, 562, 886, 1020 and c[k] = c[16-k]. Before limiting, a result equals floor(S / 32768), where S is the sum of the eight F values of its group.
- R4: The coefficients sum to 4096, so a constant input level L held for at least 24 samples gives a result of exactly L.
- R5: A result below 0 is delivered as 0, and a result above 4095 is delivered as 4095.
- R6: Input sample_valid pulses last one clock and are at least 11 clocks apart. result_valid is high for exactly one clock. It rises 11 clocks after the rising edge that accepted the 8th sample of a group.
- R7: After N samples since reset, with N >= 16, exactly floor((N-16)/8) results have been produced.
- R8: Reset empties the delay line and restarts grouping, so samples accepted before a reset have no effect on later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-clock strobe marking a new sample |
| sample_data | input | 12 | Unsigned converter sample |
| result_valid | output | 1 | One-clock strobe marking a new averaged result |
| result_data | output | 12 | Averaged, limited result |

## Verification
A fault in the delay line or in the fill count shows first as a missing or premature result around the 24th sample. After that, every later result drifts from the value the reference sum predicts. A wrong pair sum, coefficient or accumulator step corrupts the very next result, 11 clocks after the group's eighth sample. Constant-level runs expose any error in gain, and step inputs aligned to a group boundary expose faults in the limiting path. A fault in the group counter moves the strobe or breaks the one-in-eight ratio, which the timing check and the final count both see.

// File: rtl/fir_avg_pkg.sv
package fir_avg_pkg;

  // Coefficient set is tied to the tap count and scaling below.
  localparam int TAPS      = 17;
  localparam int FOLDS     = (TAPS + 1) / 2;
  localparam int CENTRE    = TAPS / 2;
  localparam int COEF_W    = 12;
  localparam int COEF_FRAC = 12;   // coefficients sum to 2**COEF_FRAC

  // Coefficient of fold j, which serves taps j and TAPS-1-j.
  // Fold CENTRE is the unpaired middle tap.
  function automatic logic signed [COEF_W-1:0] fold_coef(input int j);
    case (j)
      0:       return COEF_W'(0);
      1:       return -COEF_W'(15);
      2:       return -COEF_W'(47);
      3:       return -COEF_W'(67);
      4:       return COEF_W'(0);
      5:       return COEF_W'(219);
      6:       return COEF_W'(562);
      7:       return COEF_W'(886);
      8:       return COEF_W'(1020);
      default: return COEF_W'(0);
    endcase
  endfunction

  // Accumulator width: pair sum (sample + 1 bit), sign, coefficient,
  // growth over FOLDS products, plus one guard bit.
  function automatic int acc_width(input int sample_w);
    return sample_w + 2 + COEF_W + $clog2(FOLDS) + 1;
  endfunction

endpackage

// File: rtl/fir_tap_line.sv
module fir_tap_line
  import fir_avg_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int NTAPS    = TAPS
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [SAMPLE_W-1:0]              in_sample,
  output logic [NTAPS-1:0][SAMPLE_W-1:0]   taps,
  output logic                             start,
  output logic                             fill_done
);

  localparam int CNT_W = $clog2(NTAPS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NTAPS);
  localparam logic [CNT_W-1:0] LAST_FILL = CNT_W'(NTAPS - 1);

  logic [CNT_W-1:0] fill_cnt;
  logic             window_ready;   // this sample completes or extends a full window

  assign window_ready = in_valid && (fill_cnt >= LAST_FILL);
  assign fill_done    = (fill_cnt == FULL_CNT);

  // Shift register: tap 0 holds the newest sample.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (in_valid) begin
      for (int t = NTAPS - 1; t > 0; t--) begin
        taps[t] <= taps[t-1];
      end
      taps[0] <= in_sample;
    end
  end

  // Fill counter saturates once the line is full.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      start    <= 1'b0;
    end else begin
      start <= window_ready;
      if (in_valid && !fill_done) begin
        fill_cnt <= fill_cnt + 1'b1;
      end
    end
  end

  // R3: newest tap holds the accepted sample one clock later
  assert_tap_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (taps[0] == $past(in_sample)));

  // R2: a convolution is only launched on a full window
  assert_start_needs_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> fill_done);

endmodule

// File: rtl/fir_fold_mac.sv
module fir_fold_mac
  import fir_avg_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int NTAPS    = TAPS,
  parameter int ACC_W    = acc_width(SAMPLE_W)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [NTAPS-1:0][SAMPLE_W-1:0]   taps,
  output logic                             busy,
  output logic                             fir_valid,
  output logic signed [ACC_W-1:0]          fir_acc
);

  localparam int NFOLD  = (NTAPS + 1) / 2;
  localparam int MID    = NTAPS / 2;
  localparam int IDX_W  = $clog2(NFOLD);
  localparam int PAIR_W = SAMPLE_W + 1;
  localparam int PROD_W = PAIR_W + 1 + COEF_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NFOLD - 1);

  logic [NFOLD-1:0][PAIR_W-1:0] pair_sum;
  logic [NFOLD-1:0][COEF_W-1:0] coef_v;
  logic [IDX_W-1:0]             idx;
  logic [PAIR_W-1:0]            sel_pair;
  logic signed [COEF_W-1:0]     sel_coef;
  logic signed [PROD_W-1:0]     prod;
  logic signed [ACC_W:0]        acc_wide;
  logic signed [ACC_W-1:0]      acc;
  logic signed [ACC_W-1:0]      acc_next;
  logic                         last_step;

  // Pre-adders: mirrored taps summed, centre tap passed alone.
  for (genvar g = 0; g < NFOLD; g++) begin : g_fold
    if (g == MID) begin : g_centre
      assign pair_sum[g] = {1'b0, taps[g]};
    end else begin : g_pair
      assign pair_sum[g] = {1'b0, taps[g]} + {1'b0, taps[NTAPS-1-g]};
    end
    assign coef_v[g] = fold_coef(g);
  end

  // Operand select for the shared multiplier.
  always_comb begin
    sel_pair = '0;
    sel_coef = '0;
    for (int j = 0; j < NFOLD; j++) begin
      if (idx == IDX_W'(j)) begin
        sel_pair = pair_sum[j];
        sel_coef = coef_v[j];
      end
    end
  end

  assign prod      = $signed({1'b0, sel_pair}) * sel_coef;
  assign acc_wide  = (ACC_W+1)'(acc) + (ACC_W+1)'(prod);
  assign acc_next  = acc_wide[ACC_W-1:0];
  assign last_step = busy && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      acc       <= '0;
      fir_valid <= 1'b0;
      fir_acc   <= '0;
    end else begin
      fir_valid <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        acc  <= '0;
      end else if (busy) begin
        acc <= acc_next;
        if (last_step) begin
          busy      <= 1'b0;
          fir_valid <= 1'b1;
          fir_acc   <= acc_next;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R3: accumulator never overflows its width
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (acc_wide[ACC_W] == acc_wide[ACC_W-1]));

  // R6: a new convolution never starts on top of a running one
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R6: the final product yields a filter output on the next clock
  assert_fir_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> (fir_valid && !busy));

  // R6: filter output strobe is a single clock
  assert_fir_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fir_valid |=> !fir_valid);

endmodule

// File: rtl/fir_block_avg.sv
module fir_block_avg #(
  parameter int ACC_W    = 30,
  parameter int OUT_W    = 12,
  parameter int AVG_LOG2 = 3,
  parameter int FRAC     = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fir_valid,
  input  logic signed [ACC_W-1:0] fir_acc,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_data
);

  localparam int SUM_W = ACC_W + AVG_LOG2;
  localparam int SHIFT = FRAC + AVG_LOG2;
  localparam logic [AVG_LOG2-1:0] GROUP_END = '1;

  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] sum_next;
  logic [AVG_LOG2-1:0]     cnt;
  logic                    group_close;

  // Floor-divide the group sum and limit it to the output range.
  function automatic logic [OUT_W-1:0] scale_limit(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] q;
    q = s >>> SHIFT;
    if (q[SUM_W-1]) begin
      return '0;
    end else if (|q[SUM_W-2:OUT_W]) begin
      return '1;
    end else begin
      return q[OUT_W-1:0];
    end
  endfunction

  assign sum_next    = sum + SUM_W'(fir_acc);
  assign group_close = fir_valid && (cnt == GROUP_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (group_close) begin
        out_data  <= scale_limit(sum_next);
        out_valid <= 1'b1;
        sum       <= '0;
        cnt       <= '0;
      end else if (fir_valid) begin
        sum <= sum_next;
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: result strobe is a single clock
  assert_out_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7: every result is triggered by a filter output one clock earlier
  assert_out_follows_fir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(fir_valid));

endmodule

// File: rtl/fir_sym_avg.sv
module fir_sym_avg
  import fir_avg_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int AVG_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] sample_data,
  output logic                result_valid,
  output logic [SAMPLE_W-1:0] result_data
);

  localparam int ACC_W = acc_width(SAMPLE_W);

  logic [TAPS-1:0][SAMPLE_W-1:0] taps;
  logic                          mac_start;
  logic                          fill_done;
  logic                          mac_busy;
  logic                          fir_valid;
  logic signed [ACC_W-1:0]       fir_acc;

  fir_tap_line #(
    .SAMPLE_W (SAMPLE_W),
    .NTAPS    (TAPS)
  ) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (sample_valid),
    .in_sample (sample_data),
    .taps      (taps),
    .start     (mac_start),
    .fill_done (fill_done)
  );

  fir_fold_mac #(
    .SAMPLE_W (SAMPLE_W),
    .NTAPS    (TAPS),
    .ACC_W    (ACC_W)
  ) u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (mac_start),
    .taps      (taps),
    .busy      (mac_busy),
    .fir_valid (fir_valid),
    .fir_acc   (fir_acc)
  );

  fir_block_avg #(
    .ACC_W    (ACC_W),
    .OUT_W    (SAMPLE_W),
    .AVG_LOG2 (AVG_LOG2),
    .FRAC     (COEF_FRAC)
  ) u_avg (
    .clk       (clk),
    .rst_n     (rst_n),
    .fir_valid (fir_valid),
    .fir_acc   (fir_acc),
    .out_valid (result_valid),
    .out_data  (result_data)
  );

  // R6: samples must not arrive while a convolution is pending or running
  assert_sample_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (!mac_busy && !mac_start));

  // R2: results only exist once the delay line has filled
  assert_result_needs_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> fill_done);

endmodule

// File: tb/tb_fir_sym_avg.sv
module tb_fir_sym_avg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_valid;
  logic [11:0] sample_data;
  logic        result_valid;
  logic [11:0] result_data;

  always #5 clk = ~clk;

  fir_sym_avg dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample_data  (sample_data),
    .result_valid (result_valid),
    .result_data  (result_data)
  );

  // Full 17-entry impulse response, newest sample first (R3).
  localparam int CT [17] = '{0, -15, -47, -67, 0, 219, 562, 886, 1020,
                             886, 562, 219, 0, -67, -47, -15, 0};

  // Stimulus table: mode, a, b, length, expected last result (-1: model only)
  // mode 0 constant a; 1 alternate a/b; 2 ramp a + b*i; 3 pulse a every b; 4 prng seed a
  localparam int NSEG = 7;
  localparam int SEG_MODE [NSEG] = '{0, 0, 1, 2, 3, 4, 0};
  localparam int SEG_A    [NSEG] = '{2000, 4095, 0, 0, 4095, 1234, 0};
  localparam int SEG_B    [NSEG] = '{0, 0, 4095, 37, 9, 0, 0};
  localparam int SEG_LEN  [NSEG] = '{40, 40, 32, 48, 45, 64, 40};
  localparam int SEG_EXP  [NSEG] = '{2000, 4095, -1, -1, -1, -1, 0};

  int n_cmp = 0;
  int n_bad = 0;
  int lat_err = 0;
  int wide_err = 0;
  bit finished = 1'b0;

  // reference model state
  int     hist [17];
  int     n_seen;
  longint gsum;
  int     gcnt;
  int     n_results;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int k = 0; k < 17; k++) hist[k] = 0;
    n_seen = 0;
    gsum = 0;
    gcnt = 0;
    n_results = 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_valid = 1'b0;
    sample_data = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(result_valid), 0);
    check("R1 data in reset", int'(result_data), 0);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check("R1 valid after reset", int'(result_valid), 0);
  endtask

  // Push one sample, watch the next 11 half-cycle points, compare with model.
  task automatic push(input int x, output bit got, output int val);
    bit     exp_has;
    int     exp_val;
    longint acc;
    longint q;
    exp_has = 1'b0;
    exp_val = 0;
    for (int k = 16; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    n_seen++;
    if (n_seen >= 17) begin
      acc = 0;
      for (int k = 0; k < 17; k++) acc += longint'(CT[k]) * longint'(hist[k]);
      gsum += acc;
      gcnt++;
      if (gcnt == 8) begin
        q = gsum >>> 15;
        exp_val = (q < 0) ? 0 : ((q > 4095) ? 4095 : int'(q));
        exp_has = 1'b1;
        gsum = 0;
        gcnt = 0;
      end
    end
    @(negedge clk);
    if (result_valid) wide_err++;       // strobe must already be gone (R6)
    sample_valid = 1'b1;
    sample_data = 12'(x);
    @(negedge clk);
    sample_valid = 1'b0;
    got = 1'b0;
    val = 0;
    for (int i = 1; i <= 11; i++) begin
      @(negedge clk);
      if (result_valid) begin
        if (i != 11) lat_err++;
        got = 1'b1;
        val = int'(result_data);
      end
    end
    if (got) n_results++;
    if (got || exp_has) check("R6 result presence", int'(got), int'(exp_has));
    if (got && exp_has) check("R3 result value", val, exp_val);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit got;
    int val;
    int last;
    int x;
    int lfsr;
    int total;
    int cnt3;
    rst_n = 1'b0;
    sample_valid = 1'b0;
    sample_data = '0;
    model_reset();
    do_reset();

    // table-driven segments
    total = 0;
    for (int s = 0; s < NSEG; s++) begin
      last = -1;
      lfsr = SEG_A[s];
      for (int i = 0; i < SEG_LEN[s]; i++) begin
        case (SEG_MODE[s])
          0: x = SEG_A[s];
          1: x = (i % 2 == 1) ? SEG_B[s] : SEG_A[s];
          2: x = (SEG_A[s] + SEG_B[s] * i) % 4096;
          3: x = (i % SEG_B[s] == 0) ? SEG_A[s] : 0;
          default: begin
            x = lfsr;
            lfsr = ((lfsr << 1) | (((lfsr >> 11) ^ (lfsr >> 10) ^ (lfsr >> 9) ^ (lfsr >> 3)) & 1)) & 4095;
          end
        endcase
        push(x, got, val);
        total++;
        if (got) last = val;
      end
      if (SEG_EXP[s] >= 0) check("R4 settled constant level", last, SEG_EXP[s]);
    end
    check("R7 result count", n_results, (total - 16) / 8);

    // R8 / R2: stale samples, reset, then fill with a new level
    do_reset();
    for (int i = 0; i < 10; i++) push(4095, got, val);
    do_reset();
    for (int i = 0; i < 23; i++) push(3000, got, val);
    check("R2 nothing before 24th sample", n_results, 0);
    push(3000, got, val);
    check("R2 first result on 24th sample", int'(got), 1);
    check("R8 no stale samples after reset", val, 3000);

    // R5: falling step aligned so the third group sees only undershoot
    do_reset();
    cnt3 = 0;
    for (int i = 0; i < 40; i++) begin
      push((i < 21) ? 4095 : 0, got, val);
      if (got) begin
        cnt3++;
        if (cnt3 == 3) check("R5 limit at zero", val, 0);
      end
    end
    check("R7 results after 40 samples", cnt3, 3);

    // R5: rising step aligned so the third group sees only overshoot
    do_reset();
    cnt3 = 0;
    for (int i = 0; i < 40; i++) begin
      push((i < 21) ? 0 : 4095, got, val);
      if (got) begin
        cnt3++;
        if (cnt3 == 3) check("R5 limit at full scale", val, 4095);
      end
    end

    check("R6 strobe latency errors", lat_err, 0);
    check("R6 strobe width errors", wide_err, 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule